// File: doc/BRIEF.md
# Capture, Compare and Pulse-Width Unit

This block gives a single input/output pin three timing jobs, chosen by a 4-bit mode field. In capture modes it stores the value of an external 16-bit free-running timer when the pin shows a selected event. The event is a falling edge, a rising edge, or every fourth or sixteenth rising edge counted by an edge prescaler. In compare modes it watches for the same timer to equal a 16-bit register. On a match it raises a one-cycle interrupt pulse and then, depending on the mode, drives the pin high, drives it low, or requests a timebase reset together with a conversion start.

In pulse-width mode the block takes an 8-bit period timer plus two sub-count bits as a 10-bit running count. It drives the pin high at each period start and low once the count equals a 10-bit duty value. The top eight duty bits come from the low byte of the register and the two extra bits come from the mode write. A new duty value is moved into the active comparator only at a period start. Software reaches the block through a byte-wide write port, and the register value is visible on a read-only output.

Top module: `ccp_unit`

## Requirements
- R1: When a capture event is detected in a cycle, `reg_q` holds the `tmr16` value of that cycle from the next cycle on, and `irq` pulses high for exactly that next cycle.
- R2: Capture modes are selected by mode `4'b0100` (falling edge), `4'b0101` (rising edge), `4'b0110` (every 4th rising edge) and `4'b0111` (every 16th rising edge). Edges are judged against the pin level of the previous cycle.
- R3: A mode write that changes the mode value clears the rising-edge prescaler count. After such a write, the 4th or 16th rising edge is counted from zero again.
- R4: A capture event and a register byte write in the same cycle leave the captured timer value in `reg_q`, and the write is lost.
- R5: In compare modes (`4'b10xx`), the first cycle in which `tmr16` equals `reg_q` produces a one-cycle `irq` pulse in the next cycle. Later cycles that keep the equality produce no further pulse.
- R6: On a compare match, mode `4'b1000` drives `ccp_pin` high and mode `4'b1001` drives it low. Entering `4'b1001` sets the pin high, and entering any other non-PWM mode sets it low. Mode `4'b1010` leaves the pin unchanged.
- R7: On a compare match in mode `4'b1011`, `tmr_rst` and `conv_trig` each pulse for one cycle, in the same cycle as `irq`.
- R8: In PWM mode (`4'b11xx`), a cycle with `per_start` high makes the pin high in the next cycle if the duty value is nonzero, and low otherwise. The pin goes low in the cycle after `{tmr8, tmr8_frac}` equals the active duty value.
- R9: The duty value `{reg_q[7:0], frac field}` is taken into the active comparator only in a cycle with `per_start` high. A duty write in the middle of a period leaves the current period's pulse unchanged.
- R10: After reset, `ccp_pin`, `irq`, `tmr_rst` and `conv_trig` are low, `reg_q` is zero, and the mode is off (`4'b0000`). Internal reset is released two clock edges after `rst_n` rises.
- R11: Writes use `wr_addr` 0 for the mode field (`wr_data[3:0]`) and the duty fraction (`wr_data[5:4]`), 1 for the low byte of `reg_q`, and 2 for the high byte. A write to address 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr16 | input | 16 | 16-bit timebase value |
| tmr8 | input | 8 | PWM period timer |
| tmr8_frac | input | 2 | Sub-count bits extending the PWM timer |
| per_start | input | 1 | High in the first cycle of each PWM period |
| cap_in | input | 1 | Pin level used for capture events |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 8 | Write data |
| ccp_pin | output | 1 | Compare or PWM pin drive |
| irq | output | 1 | One-cycle event pulse |
| tmr_rst | output | 1 | Timebase reset request pulse |
| conv_trig | output | 1 | Conversion start pulse |
| reg_q | output | 16 | Capture, compare or duty register |

## Verification
A capture event and a software byte write to the register can happen in the same cycle. The bench provokes this by putting a rising edge on `cap_in` in the very cycle that writes the low byte. It then expects the timer value, not the written byte, in `reg_q` one cycle later. A duty rewrite and a period start can also meet, as can a mode change and a prescaled edge. A behavioural model updated every clock judges all these cases by comparing every output of the block after each edge.

// File: rtl/ccp_pkg.sv
package ccp_pkg;
  localparam logic [3:0] M_OFF      = 4'b0000;
  localparam logic [3:0] M_CMP_SET  = 4'b1000;
  localparam logic [3:0] M_CMP_CLR  = 4'b1001;
  localparam logic [3:0] M_CMP_SPC  = 4'b1011;

  localparam logic [1:0] SEL_FALL   = 2'b00;
  localparam logic [1:0] SEL_RISE   = 2'b01;
  localparam logic [1:0] SEL_RISE4  = 2'b10;

  localparam logic [1:0] A_MODE = 2'd0;
  localparam logic [1:0] A_LO   = 2'd1;
  localparam logic [1:0] A_HI   = 2'd2;

  function automatic logic mode_is_cap(input logic [3:0] m);
    return m[3:2] == 2'b01;
  endfunction

  function automatic logic mode_is_cmp(input logic [3:0] m);
    return m[3:2] == 2'b10;
  endfunction

  function automatic logic mode_is_pwm(input logic [3:0] m);
    return m[3:2] == 2'b11;
  endfunction
endpackage

// File: rtl/ccp_cap_edge.sv
module ccp_cap_edge import ccp_pkg::*; #(
  parameter int PSW = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [1:0] sel,
  input  logic       clr,
  input  logic       pin,
  output logic       evt
);
  localparam logic [PSW-1:0] LIM_WIDE  = {PSW{1'b1}};
  localparam logic [PSW-1:0] LIM_SHORT = PSW'(3);

  logic           pin_d;
  logic [PSW-1:0] cnt_q, cnt_nx;
  logic           rise, fall;
  logic [PSW-1:0] lim;

  always_comb begin
    rise = pin & ~pin_d;
    fall = ~pin & pin_d;
    lim  = (sel == SEL_RISE4) ? LIM_SHORT : LIM_WIDE;
    evt  = 1'b0;
    if (en) begin
      unique case (sel)
        SEL_FALL: evt = fall;
        SEL_RISE: evt = rise;
        default:  evt = rise && (cnt_q == lim);
      endcase
    end
    cnt_nx = cnt_q;
    if (clr || !en)
      cnt_nx = '0;
    else if (sel[1] && rise)
      cnt_nx = (cnt_q == lim) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_d <= 1'b0;
      cnt_q <= '0;
    end else begin
      pin_d <= pin;
      cnt_q <= cnt_nx;
    end
  end

  AST_PRESC_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt_q == '0); // R3
endmodule

// File: rtl/ccp_pwm.sv
module ccp_pwm #(
  parameter int PW = 8,
  parameter int XW = 2,
  localparam int DW = PW + XW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          per_start,
  input  logic [PW-1:0] tmr,
  input  logic [XW-1:0] frac,
  input  logic [DW-1:0] duty_new,
  output logic          q
);
  logic [DW-1:0] act_q, act_nx;
  logic          q_nx;
  logic [DW-1:0] ext;

  always_comb begin
    ext    = {tmr, frac};
    act_nx = act_q;
    q_nx   = q;
    if (!en) begin
      q_nx = 1'b0;
    end else if (per_start) begin
      act_nx = duty_new;
      q_nx   = (duty_new != '0);
    end else if (ext == act_q) begin
      q_nx = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
      q     <= 1'b0;
    end else begin
      act_q <= act_nx;
      q     <= q_nx;
    end
  end

  AST_DUTY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !per_start |=> $stable(act_q)); // R9
  AST_PWM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !q); // R8
endmodule

// File: rtl/ccp_unit.sv
module ccp_unit import ccp_pkg::*; #(
  parameter int TW  = 16,
  parameter int PW  = 8,
  parameter int XW  = 2,
  parameter int PSW = 4,
  parameter bit HAS_TRIG = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] tmr16,
  input  logic [PW-1:0] tmr8,
  input  logic [XW-1:0] tmr8_frac,
  input  logic          per_start,
  input  logic          cap_in,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [TW/2-1:0] wr_data,
  output logic          ccp_pin,
  output logic          irq,
  output logic          tmr_rst,
  output logic          conv_trig,
  output logic [TW-1:0] reg_q
);
  localparam int BW = TW / 2;
  localparam int DW = PW + XW;
  localparam int FLO = 4;

  logic [1:0]    rs_q;
  logic          rst_i;
  logic [3:0]    mode_q, mode_nx;
  logic [XW-1:0] dlo_q, dlo_nx;
  logic [TW-1:0] reg_nx;
  logic          match_d, match;
  logic          cpin_q, cpin_nx;
  logic          irq_nx, trst_nx, trig_nx;
  logic          mode_wr, mode_chg;
  logic [3:0]    new_mode;
  logic          cap_evt, cmp_evt;
  logic          is_cap_m, is_cmp_m, is_pwm_m;
  logic          pwm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  ccp_cap_edge #(.PSW(PSW)) u_edge (
    .clk(clk), .rst_n(rst_i), .en(is_cap_m), .sel(mode_q[1:0]),
    .clr(mode_chg), .pin(cap_in), .evt(cap_evt)
  );

  ccp_pwm #(.PW(PW), .XW(XW)) u_pwm (
    .clk(clk), .rst_n(rst_i), .en(is_pwm_m), .per_start(per_start),
    .tmr(tmr8), .frac(tmr8_frac), .duty_new({reg_q[PW-1:0], dlo_q}), .q(pwm_q)
  );

  always_comb begin
    is_cap_m = mode_is_cap(mode_q);
    is_cmp_m = mode_is_cmp(mode_q);
    is_pwm_m = mode_is_pwm(mode_q);
    new_mode = wr_data[3:0];
    mode_wr  = wr_en && (wr_addr == A_MODE);
    mode_chg = mode_wr && (new_mode != mode_q);
    match    = is_cmp_m && (tmr16 == reg_q);
    cmp_evt  = match && !match_d;

    mode_nx = mode_wr ? new_mode : mode_q;
    dlo_nx  = mode_wr ? wr_data[FLO+XW-1:FLO] : dlo_q;

    reg_nx = reg_q;
    if (cap_evt)
      reg_nx = tmr16;
    else if (wr_en && wr_addr == A_LO)
      reg_nx[BW-1:0] = wr_data;
    else if (wr_en && wr_addr == A_HI)
      reg_nx[TW-1:BW] = wr_data;

    cpin_nx = cpin_q;
    if (mode_chg)
      cpin_nx = (new_mode == M_CMP_CLR);
    else if (cmp_evt && mode_q == M_CMP_SET)
      cpin_nx = 1'b1;
    else if (cmp_evt && mode_q == M_CMP_CLR)
      cpin_nx = 1'b0;

    irq_nx  = cap_evt | cmp_evt;
    trst_nx = cmp_evt && (mode_q == M_CMP_SPC);
  end

  if (HAS_TRIG) begin : g_trig
    assign trig_nx = trst_nx;
  end else begin : g_no_trig
    assign trig_nx = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      mode_q    <= M_OFF;
      dlo_q     <= '0;
      reg_q     <= '0;
      match_d   <= 1'b0;
      cpin_q    <= 1'b0;
      irq       <= 1'b0;
      tmr_rst   <= 1'b0;
      conv_trig <= 1'b0;
    end else begin
      mode_q    <= mode_nx;
      dlo_q     <= dlo_nx;
      reg_q     <= reg_nx;
      match_d   <= match;
      cpin_q    <= cpin_nx;
      irq       <= irq_nx;
      tmr_rst   <= trst_nx;
      conv_trig <= trig_nx;
    end
  end

  assign ccp_pin = is_pwm_m ? pwm_q : cpin_q;

  AST_CAP_LOADS: assert property (@(posedge clk) disable iff (!rst_i)
    cap_evt |=> reg_q == $past(tmr16)); // R1
  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_i)
    irq |-> $past(is_cap_m || is_cmp_m)); // R5
  AST_TRST_SPECIAL: assert property (@(posedge clk) disable iff (!rst_i)
    tmr_rst |-> ($past(mode_q) == M_CMP_SPC) && irq); // R7
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_i)
    (irq && $past(is_cmp_m) && is_cmp_m && $stable(reg_q) && $stable(tmr16)) |=> !irq); // R5
endmodule

// File: tb/ccp_unit_tb.sv
module ccp_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] tmr16 = '0;
  logic [7:0]  tmr8 = '0;
  logic [1:0]  tmr8_frac = '0;
  logic        per_start = 1'b0;
  logic        cap_in = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        ccp_pin, irq, tmr_rst, conv_trig;
  logic [15:0] reg_q;

  ccp_unit u_dut (
    .clk(clk), .rst_n(rst_n), .tmr16(tmr16), .tmr8(tmr8), .tmr8_frac(tmr8_frac),
    .per_start(per_start), .cap_in(cap_in), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ccp_pin(ccp_pin), .irq(irq), .tmr_rst(tmr_rst),
    .conv_trig(conv_trig), .reg_q(reg_q)
  );

  always #4 clk = ~clk;

  int total = 0;
  int bad = 0;
  string tag = "R10";
  bit run16 = 0;
  bit runpwm = 0;
  int pwm_e = 0;
  int pwm_len = 40;

  logic [1:0]  m_rs;
  logic [3:0]  m_mode;
  logic [1:0]  m_dlo;
  logic [15:0] m_reg;
  logic        m_capd, m_matchd, m_cpin, m_irq, m_trst, m_trig, m_pwm;
  int          m_cnt;
  int          m_act;

  task automatic model_reset();
    m_mode = 0; m_dlo = 0; m_reg = 0; m_capd = 0; m_matchd = 0; m_cpin = 0;
    m_irq = 0; m_trst = 0; m_trig = 0; m_pwm = 0; m_cnt = 0; m_act = 0;
  endtask

  task automatic model_step();
    bit capm, cmpm, pwmm, rise, fall, ev, match, cev, mw, chg;
    int lim, ext, duty;
    logic [15:0] r;
    if (!rst_n) begin
      m_rs = 0; model_reset(); return;
    end
    if (!m_rs[1]) begin
      m_rs = {m_rs[0], 1'b1}; model_reset(); return;
    end
    capm = (m_mode >= 4 && m_mode <= 7);
    cmpm = (m_mode >= 8 && m_mode <= 11);
    pwmm = (m_mode >= 12);
    rise = cap_in && !m_capd;
    fall = !cap_in && m_capd;
    lim  = (m_mode == 6) ? 3 : 15;
    ev = 0;
    if (capm) begin
      if (m_mode == 4) ev = fall;
      else if (m_mode == 5) ev = rise;
      else ev = rise && (m_cnt == lim);
    end
    mw  = wr_en && wr_addr == 0;
    chg = mw && (wr_data[3:0] != m_mode);
    if (chg || !capm) m_cnt = 0;
    else if (m_mode >= 6 && rise) m_cnt = (m_cnt == lim) ? 0 : m_cnt + 1;
    m_capd = cap_in;
    match = cmpm && (tmr16 == m_reg);
    cev = match && !m_matchd;
    m_matchd = match;
    if (chg) m_cpin = (wr_data[3:0] == 4'd9);
    else if (cev && m_mode == 8) m_cpin = 1;
    else if (cev && m_mode == 9) m_cpin = 0;
    m_irq = ev || cev;
    m_trst = cev && m_mode == 11;
    m_trig = m_trst;
    duty = {m_reg[7:0], m_dlo};
    ext = {tmr8, tmr8_frac};
    if (!pwmm) m_pwm = 0;
    else if (per_start) begin m_act = duty; m_pwm = (duty != 0); end
    else if (ext == m_act) m_pwm = 0;
    r = m_reg;
    if (ev) r = tmr16;
    else if (wr_en && wr_addr == 1) r[7:0] = wr_data;
    else if (wr_en && wr_addr == 2) r[15:8] = wr_data;
    m_reg = r;
    if (mw) begin m_mode = wr_data[3:0]; m_dlo = wr_data[5:4]; end
  endtask

  task automatic chk(string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic cyc();
    bit pin_exp;
    model_step();
    @(negedge clk);
    pin_exp = (m_mode >= 12) ? m_pwm : m_cpin;
    chk("ccp_pin", int'(ccp_pin), int'(pin_exp));
    chk("irq", int'(irq), int'(m_irq));
    chk("tmr_rst", int'(tmr_rst), int'(m_trst));
    chk("conv_trig", int'(conv_trig), int'(m_trig));
    chk("reg_q", int'(reg_q), int'(m_reg));
    if (run16) tmr16 = tmr16 + 16'd1;
    if (runpwm) begin
      pwm_e = (pwm_e + 1) % pwm_len;
      tmr8 = 8'(pwm_e >> 2);
      tmr8_frac = 2'(pwm_e & 3);
      per_start = (pwm_e == 0);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    cyc();
    wr_en = 0;
  endtask

  task automatic pulses(int n);
    for (int i = 0; i < n; i++) begin
      cap_in = 1; cyc(); cyc();
      cap_in = 0; cyc(); cyc();
    end
  endtask

  initial begin
    #(200000 * 8);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    m_rs = 0; model_reset();
    tag = "R10";
    idle(3);
    @(negedge clk); rst_n = 1;
    idle(4);

    tag = "R11";
    wr(1, 8'h34); wr(2, 8'h12); wr(3, 8'hFF); idle(2);

    tag = "R1";
    run16 = 1;
    wr(0, 8'h05); pulses(3);
    tag = "R2";
    wr(0, 8'h04); pulses(3);
    wr(0, 8'h06); pulses(9);
    wr(0, 8'h07); pulses(34);
    tag = "R3";
    pulses(5); wr(0, 8'h06); pulses(5);
    wr(0, 8'h07); pulses(3); wr(0, 8'h07); pulses(14);

    tag = "R4";
    wr(0, 8'h05); idle(2);
    cap_in = 1; wr(1, 8'hAA); idle(2); cap_in = 0; idle(2);
    cap_in = 1; wr(2, 8'h55); idle(2); cap_in = 0; idle(2);

    tag = "R5";
    run16 = 0; tmr16 = 16'h0000;
    wr(1, 8'h10); wr(2, 8'h00); wr(0, 8'h0A);
    run16 = 1; idle(24);
    run16 = 0; tmr16 = 16'h0010; idle(4);
    tag = "R6";
    tmr16 = 0; wr(0, 8'h08); run16 = 1; idle(24);
    run16 = 0; tmr16 = 0; wr(0, 8'h09); run16 = 1; idle(24);
    run16 = 0; tmr16 = 0; wr(0, 8'h0A); run16 = 1; idle(24);

    tag = "R7";
    run16 = 0; tmr16 = 0; wr(0, 8'h0B); run16 = 1; idle(24);
    run16 = 0;

    tag = "R8";
    wr(1, 8'h05); wr(0, 8'h2C);
    pwm_e = pwm_len - 1; runpwm = 1;
    idle(100);
    tag = "R9";
    idle(10); wr(1, 8'h08); idle(100);
    idle(5); wr(0, 8'h1C); idle(90);
    tag = "R8";
    wr(1, 8'h00); wr(0, 8'h0C); idle(90);
    wr(1, 8'hFF); idle(90);
    wr(0, 8'h00); idle(10);

    tag = "R10";
    @(negedge clk); rst_n = 0;
    idle(2);
    @(negedge clk); rst_n = 1;
    idle(4);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule